// File: doc/BRIEF.md
# SCSI Initiator Arbitration and Selection Sequencer

This block runs the bus side of a select command for a SCSI initiator. A command front end pulses a start strobe with a command code. The sequencer then polls the bus until it is free and arbitrates with its own ID. If arbitration cannot start or is lost, it drops its drives and goes back to polling. Once it wins, it selects the programmed target and waits for that target to answer or for the selection timer to run out.

Each wait is a cycle count taken from a parameter. The selection window is the programmed timeout value times the clock factor times a scale parameter. A small step table for the command fixes the state entered after winning, and the step number and status bits reported when the sequence stops. A one-cycle done pulse returns control to the front end.

Top module: `scsi_sel_seq`

## Requirements
- R1: After reset, all bus drives (`bsyOut`, `selOut`, `atnOut`, `dataOut`) are low, `seqStep` and `intStatus` are zero and `done` is low.
- R2: With the start strobe sampled at clock edge 0, the bus is polled at edge 1 and then every FREE_DLY+1 edges while `busFree` is low. A poll at edge p that finds the bus free starts arbitration at edge p+FREE_DLY+SETTLE_DLY+1.
- R3: Arbitration asserts `bsyOut` and puts only bit `ownId` on `dataOut`, with `selOut` low.
- R4: If `busFree` is low when arbitration is due, no line is driven and polling resumes CLEAR_DLY+1 edges later.
- R5: If `arbWon` is low when arbitration ends (ARB_DLY+1 edges after it starts), all drives drop on that edge and polling resumes CLEAR_DLY+1 edges later.
- R6: A won arbitration leads, CLEAR_DLY+SETTLE_DLY+1 edges later, to selection: `selOut` high, `bsyOut` kept high, and `dataOut` carrying bits `ownId` and `targetId`.
- R7: During selection `atnOut` is high unless the command code is 8'h41, in which case it is low. `atnOut` is never high outside selection.
- R8: With T = timeoutReg*clkFactor*TO_SCALE and selection on edge s, the timeout fires on edge s+T+1 if no target answers. On that edge `seqStep` becomes 2, bits 4 (service request) and 3 (successful operation) are set in `intStatus` (8'h18), all drives drop and `done` pulses for one cycle.
- R9: A `targetResp` with `respId` equal to `targetId`, sampled on an edge from s+1 to s+T+1, cancels the timer. On the next edge `seqStep` becomes 3, `intStatus` gets 8'h18, the drives drop and `done` pulses.
- R10: A `targetResp` with any other `respId` has no effect: the timeout still fires on edge s+T+1 with `seqStep` 2.
- R11: A matching response on edge s+T+1, the same edge on which the timer runs out, takes priority: the result is that of R9, one edge later.
- R12: `intStatus` is cleared when a command starts. A start strobe while a sequence is running is ignored, so neither its timing nor its attention choice changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startStb | input | 1 | Command start pulse |
| cmdCode | input | 8 | Command code, latched at start |
| ownId | input | ID_W | Own bus ID |
| targetId | input | ID_W | Target bus ID |
| timeoutReg | input | 8 | Programmed selection timeout value |
| clkFactor | input | 4 | Clock factor scaling the timeout |
| busFree | input | 1 | Bus is in the free phase |
| arbWon | input | 1 | Arbitration result at arbitration end |
| targetResp | input | 1 | Target answered selection |
| respId | input | ID_W | ID of the answering target |
| bsyOut | output | 1 | BSY drive |
| selOut | output | 1 | SEL drive |
| atnOut | output | 1 | ATN drive |
| dataOut | output | 2**ID_W | Data bus ID bit drives |
| seqStep | output | 3 | Sequence step at stop |
| intStatus | output | 8 | Interrupt status bits |
| done | output | 1 | One-cycle pulse when the sequencer returns to idle |

## Verification
A target answer and the expiry of the selection timer can land on the same edge. This is the last edge on which the sequencer is still waiting in selection end. The bench provokes it by timing the response pulse to edge s+T+1, both in a directed case and at random when the drawn offset hits that edge. It judges the outcome by the done edge (one later than a plain timeout) and by step value 3 rather than 2. Wrong-ID responses on that same edge must still give the timeout result.

// File: rtl/scsi_sel_pkg.sv
package scsi_sel_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE     = 3'd0,
    SQ_BUSFREE  = 3'd1,
    SQ_ARBBEGIN = 3'd2,
    SQ_ARBEND   = 3'd3,
    SQ_SELBEGIN = 3'd4,
    SQ_SELEND   = 3'd5,
    SQ_CMDBEGIN = 3'd6,
    SQ_CMDDONE  = 3'd7
  } seqState_t;

  typedef enum logic [2:0] {
    DLY_NONE, DLY_FREE, DLY_FREE_SETTLE, DLY_CLEAR,
    DLY_CLEAR_SETTLE, DLY_ARB, DLY_TIMEOUT
  } dlyKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     latchCmd;
    logic     loadCnt;
    dlyKind_t dly;
    logic     decCnt;
    logic     advPtr;
    logic     report;
    logic     driveArb;
    logic     driveSel;
    logic     dropAll;
  } dpCtrl_t;

  localparam logic [7:0] CMD_SEL_NOATN = 8'h41;
  localparam logic [7:0] ST_SVCREQ     = 8'h10;
  localparam logic [7:0] ST_SUCCESS    = 8'h08;

  // step table of the select command
  function automatic seqState_t descState(input logic [1:0] idx);
    case (idx)
      2'd0:    return SQ_SELBEGIN;
      2'd1:    return SQ_CMDBEGIN;
      default: return SQ_CMDDONE;
    endcase
  endfunction

  function automatic logic [2:0] descStep(input logic [1:0] idx);
    case (idx)
      2'd0:    return 3'd2;
      2'd1:    return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [7:0] descStat(input logic [1:0] idx);
    return (idx > 2'd2) ? 8'h00 : (ST_SVCREQ | ST_SUCCESS);
  endfunction

endpackage

// File: rtl/scsi_sel_dp.sv
module scsi_sel_dp
  import scsi_sel_pkg::*;
#(
  parameter int ID_W       = 3,
  parameter int CNT_W      = 20,
  parameter int FREE_DLY   = 200,
  parameter int SETTLE_DLY = 100,
  parameter int CLEAR_DLY  = 200,
  parameter int ARB_DLY    = 600,
  parameter int TO_SCALE   = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpCtrl_t                ctl,
  input  logic [7:0]             cmdCode,
  input  logic [ID_W-1:0]        ownId,
  input  logic [ID_W-1:0]        targetId,
  input  logic [7:0]             timeoutReg,
  input  logic [3:0]             clkFactor,
  input  logic [ID_W-1:0]        respId,
  output logic                   cntZero,
  output logic                   idMatch,
  output seqState_t              curState,
  output seqState_t              advState,
  output logic                   bsyOut,
  output logic                   selOut,
  output logic                   atnOut,
  output logic [(1<<ID_W)-1:0]   dataOut,
  output logic [2:0]             seqStep,
  output logic [7:0]             intStatus
);
  localparam int BUS_W = 1 << ID_W;

  logic [CNT_W-1:0] cnt, loadVal;
  logic [1:0]       ptr;
  logic             atnMode;
  logic [BUS_W-1:0] ownBit, tgtBit;

  assign ownBit   = BUS_W'(1) << ownId;
  assign tgtBit   = BUS_W'(1) << targetId;
  assign cntZero  = (cnt == '0);
  assign idMatch  = (respId == targetId);
  assign curState = descState(ptr);
  assign advState = descState(ptr + 2'd1);

  always_comb begin
    case (ctl.dly)
      DLY_FREE:         loadVal = CNT_W'(FREE_DLY);
      DLY_FREE_SETTLE:  loadVal = CNT_W'(FREE_DLY + SETTLE_DLY);
      DLY_CLEAR:        loadVal = CNT_W'(CLEAR_DLY);
      DLY_CLEAR_SETTLE: loadVal = CNT_W'(CLEAR_DLY + SETTLE_DLY);
      DLY_ARB:          loadVal = CNT_W'(ARB_DLY);
      DLY_TIMEOUT:      loadVal = CNT_W'(32'(timeoutReg) * 32'(clkFactor) * 32'(TO_SCALE));
      default:          loadVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (ctl.loadCnt) cnt <= loadVal;
    else if (ctl.decCnt) cnt <= cnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr       <= '0;
      atnMode   <= 1'b0;
      seqStep   <= '0;
      intStatus <= '0;
    end else begin
      if (ctl.latchCmd) begin
        ptr       <= '0;
        atnMode   <= (cmdCode != CMD_SEL_NOATN);
        intStatus <= '0;
      end else begin
        if (ctl.advPtr) ptr <= ptr + 2'd1;
        if (ctl.report) begin
          seqStep   <= descStep(ptr);
          intStatus <= intStatus | descStat(ptr);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bsyOut <= 1'b0; selOut <= 1'b0; atnOut <= 1'b0; dataOut <= '0;
    end else if (ctl.dropAll) begin
      bsyOut <= 1'b0; selOut <= 1'b0; atnOut <= 1'b0; dataOut <= '0;
    end else if (ctl.driveArb) begin
      bsyOut <= 1'b1; selOut <= 1'b0; atnOut <= 1'b0; dataOut <= ownBit;
    end else if (ctl.driveSel) begin
      selOut <= 1'b1; atnOut <= atnMode; dataOut <= ownBit | tgtBit;
    end
  end
endmodule

// File: rtl/scsi_sel_ctrl.sv
module scsi_sel_ctrl
  import scsi_sel_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startStb,
  input  logic      busFree,
  input  logic      arbWon,
  input  logic      targetResp,
  input  logic      idMatch,
  input  logic      cntZero,
  input  seqState_t curState,
  input  seqState_t advState,
  output dpCtrl_t   ctl,
  output logic      done
);
  seqState_t state, nxtState;
  logic      doneNxt, respHit;

  assign respHit = targetResp && idMatch;

  always_comb begin
    ctl      = '0;
    nxtState = state;
    doneNxt  = 1'b0;
    if (state == SQ_IDLE) begin
      if (startStb) begin
        ctl.latchCmd = 1'b1;
        ctl.loadCnt  = 1'b1;
        ctl.dly      = DLY_NONE;
        nxtState     = SQ_BUSFREE;
      end
    end else if (state == SQ_SELEND && respHit) begin
      // answer beats an expiring timer
      ctl.advPtr  = 1'b1;
      ctl.loadCnt = 1'b1;
      ctl.dly     = DLY_NONE;
      nxtState    = advState;
    end else if (!cntZero) begin
      ctl.decCnt = 1'b1;
    end else begin
      case (state)
        SQ_BUSFREE: begin
          ctl.loadCnt = 1'b1;
          if (busFree) begin
            ctl.dly  = DLY_FREE_SETTLE;
            nxtState = SQ_ARBBEGIN;
          end else begin
            ctl.dly  = DLY_FREE;
          end
        end
        SQ_ARBBEGIN: begin
          ctl.loadCnt = 1'b1;
          if (busFree) begin
            ctl.driveArb = 1'b1;
            ctl.dly      = DLY_ARB;
            nxtState     = SQ_ARBEND;
          end else begin
            ctl.dropAll = 1'b1;
            ctl.dly     = DLY_CLEAR;
            nxtState    = SQ_BUSFREE;
          end
        end
        SQ_ARBEND: begin
          ctl.loadCnt = 1'b1;
          if (arbWon) begin
            ctl.dly  = DLY_CLEAR_SETTLE;
            nxtState = curState;
          end else begin
            ctl.dropAll = 1'b1;
            ctl.dly     = DLY_CLEAR;
            nxtState    = SQ_BUSFREE;
          end
        end
        SQ_SELBEGIN: begin
          ctl.driveSel = 1'b1;
          ctl.loadCnt  = 1'b1;
          ctl.dly      = DLY_TIMEOUT;
          nxtState     = SQ_SELEND;
        end
        default: begin
          ctl.report  = 1'b1;
          ctl.dropAll = 1'b1;
          doneNxt     = 1'b1;
          nxtState    = SQ_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= SQ_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nxtState;
      done  <= doneNxt;
    end
  end
endmodule

// File: rtl/scsi_sel_seq.sv
module scsi_sel_seq
  import scsi_sel_pkg::*;
#(
  parameter int ID_W       = 3,
  parameter int CNT_W      = 20,
  parameter int FREE_DLY   = 200,
  parameter int SETTLE_DLY = 100,
  parameter int CLEAR_DLY  = 200,
  parameter int ARB_DLY    = 600,
  parameter int TO_SCALE   = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startStb,
  input  logic [7:0]           cmdCode,
  input  logic [ID_W-1:0]      ownId,
  input  logic [ID_W-1:0]      targetId,
  input  logic [7:0]           timeoutReg,
  input  logic [3:0]           clkFactor,
  input  logic                 busFree,
  input  logic                 arbWon,
  input  logic                 targetResp,
  input  logic [ID_W-1:0]      respId,
  output logic                 bsyOut,
  output logic                 selOut,
  output logic                 atnOut,
  output logic [(1<<ID_W)-1:0] dataOut,
  output logic [2:0]           seqStep,
  output logic [7:0]           intStatus,
  output logic                 done
);
  dpCtrl_t   ctl;
  logic      cntZero, idMatch;
  seqState_t curState, advState;

  scsi_sel_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startStb(startStb), .busFree(busFree),
    .arbWon(arbWon), .targetResp(targetResp), .idMatch(idMatch),
    .cntZero(cntZero), .curState(curState), .advState(advState),
    .ctl(ctl), .done(done)
  );

  scsi_sel_dp #(
    .ID_W(ID_W), .CNT_W(CNT_W), .FREE_DLY(FREE_DLY), .SETTLE_DLY(SETTLE_DLY),
    .CLEAR_DLY(CLEAR_DLY), .ARB_DLY(ARB_DLY), .TO_SCALE(TO_SCALE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmdCode(cmdCode), .ownId(ownId),
    .targetId(targetId), .timeoutReg(timeoutReg), .clkFactor(clkFactor),
    .respId(respId), .cntZero(cntZero), .idMatch(idMatch),
    .curState(curState), .advState(advState), .bsyOut(bsyOut),
    .selOut(selOut), .atnOut(atnOut), .dataOut(dataOut),
    .seqStep(seqStep), .intStatus(intStatus)
  );
endmodule

// File: rtl/scsi_sel_seq_chk.sv
module scsi_sel_seq_chk #(
  parameter int ID_W = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ID_W-1:0]      ownId,
  input logic [ID_W-1:0]      targetId,
  input logic                 bsyOut,
  input logic                 selOut,
  input logic                 atnOut,
  input logic [(1<<ID_W)-1:0] dataOut,
  input logic [2:0]           seqStep,
  input logic                 done
);
  localparam int BUS_W = 1 << ID_W;
  logic [BUS_W-1:0] ownBit, tgtBit;
  assign ownBit = BUS_W'(1) << ownId;
  assign tgtBit = BUS_W'(1) << targetId;

  // R6
  sel_keeps_bsy_chk: assert property (@(posedge clk) disable iff (!rstN)
    selOut |-> bsyOut);

  // R7
  atn_in_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    atnOut |-> selOut);

  // R3
  arb_own_id_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bsyOut) |-> (dataOut == ownBit) && !selOut);

  // R6
  sel_both_ids_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selOut) |-> dataOut == (ownBit | tgtBit));

  // R8
  done_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !bsyOut && !selOut && !atnOut && (dataOut == '0));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  step_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(seqStep) |-> done);
endmodule

bind scsi_sel_seq scsi_sel_seq_chk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rstN(rstN), .ownId(ownId), .targetId(targetId),
  .bsyOut(bsyOut), .selOut(selOut), .atnOut(atnOut), .dataOut(dataOut),
  .seqStep(seqStep), .done(done)
);

// File: tb/scsi_sel_seq_test.sv
module scsi_sel_seq_test;
  localparam int F = 3, S = 2, C = 2, A = 4, SC = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic startStb = 1'b0, busFree = 1'b1, arbWon = 1'b1, targetResp = 1'b0;
  logic [7:0] cmdCode = 8'h41, timeoutReg = 8'd1;
  logic [3:0] clkFactor = 4'd1;
  logic [2:0] ownId = 3'd7, targetId = 3'd0, respId = 3'd0;
  logic bsyOut, selOut, atnOut, done;
  logic [7:0] dataOut, intStatus;
  logic [2:0] seqStep;

  int cyc = 0, t0 = 0, nChecks = 0, nErr = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  scsi_sel_seq #(.ID_W(3), .CNT_W(16), .FREE_DLY(F), .SETTLE_DLY(S),
                 .CLEAR_DLY(C), .ARB_DLY(A), .TO_SCALE(SC)) uut (
    .clk(clk), .rstN(rstN), .startStb(startStb), .cmdCode(cmdCode),
    .ownId(ownId), .targetId(targetId), .timeoutReg(timeoutReg),
    .clkFactor(clkFactor), .busFree(busFree), .arbWon(arbWon),
    .targetResp(targetResp), .respId(respId), .bsyOut(bsyOut),
    .selOut(selOut), .atnOut(atnOut), .dataOut(dataOut),
    .seqStep(seqStep), .intStatus(intStatus), .done(done)
  );

  always @(posedge clk) begin
    if (cyc == 150000) begin
      nErr++;
      $display("FAIL watchdog (all requirements) actual=%0d expected<150000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  function automatic int armEdge(input int poll); return poll + F + S + 1; endfunction
  function automatic int selEdge(); return F + 2*S + A + C + 4; endfunction
  function automatic int toLen(input int tr, input int cf); return tr * cf * SC; endfunction
  function automatic int firstPoll(input int p);
    int m = (p <= 1) ? 0 : (p - 1 + F) / (F + 1);
    return 1 + m * (F + 1);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic startCmd(input logic [7:0] cmd);
    @(negedge clk); startStb = 1'b1; cmdCode = cmd;
    @(negedge clk); startStb = 1'b0; t0 = cyc;
  endtask

  // which: 0 bsy high, 1 sel high, 2 done, 3 bsy low
  task automatic waitEvt(input int which, output int at);
    at = -1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ((which == 0 && bsyOut) || (which == 1 && selOut) ||
          (which == 2 && done) || (which == 3 && !bsyOut)) begin
        at = cyc - t0;
        break;
      end
    end
  endtask

  // mode 0: no answer, 1: matching answer at offset k, 2: wrong-ID answer at offset k
  task automatic runSel(input int own, input int tgt, input logic [7:0] cmd,
                        input int tr, input int cf, input int mode, input int k);
    int at, tt, eSel;
    ownId = 3'(own); targetId = 3'(tgt); timeoutReg = 8'(tr); clkFactor = 4'(cf);
    busFree = 1'b1; arbWon = 1'b1; targetResp = 1'b0;
    tt = toLen(tr, cf); eSel = selEdge();
    startCmd(cmd);
    chk("R12 status cleared at start", int'(intStatus), 0);
    waitEvt(0, at);
    chk("R2 arbitration edge", at, armEdge(1));
    chk("R3 arbitration id bits", int'(dataOut), 1 << own);
    chk("R3 no sel in arbitration", int'(selOut), 0);
    waitEvt(1, at);
    chk("R6 selection edge", at, eSel);
    chk("R6 selection id bits", int'(dataOut), (1 << own) | (1 << tgt));
    chk("R7 atn choice", int'(atnOut), int'(cmd != 8'h41));
    if (mode != 0) begin
      repeat (k - 1) @(negedge clk);
      targetResp = 1'b1;
      respId = (mode == 1) ? 3'(tgt) : 3'((tgt + 1 + $urandom % 7) % 8);
      @(posedge clk); #1 targetResp = 1'b0;
    end
    waitEvt(2, at);
    if (mode == 1) begin
      chk((k == tt + 1) ? "R11 answer beats timer" : "R9 answer edge", at, eSel + k + 1);
      chk("R9 step after answer", int'(seqStep), 3);
    end else begin
      chk((mode == 2) ? "R10 wrong id ignored" : "R8 timeout edge", at, eSel + tt + 1);
      chk("R8 step after timeout", int'(seqStep), 2);
    end
    chk("R8 status bits", int'(intStatus), 8'h18);
    chk("R8 lines dropped", int'({bsyOut, selOut, atnOut}), 0);
    chk("R8 data dropped", int'(dataOut), 0);
  endtask

  initial begin
    int at, p, seedDummy;
    seedDummy = $urandom(32'd2024);

    repeat (3) @(negedge clk);
    chk("R1 drives in reset", int'({bsyOut, selOut, atnOut}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 drives after reset", int'({bsyOut, selOut, atnOut}), 0);
    chk("R1 data after reset", int'(dataOut), 0);
    chk("R1 step/status after reset", int'({seqStep, intStatus}), 0);
    chk("R1 done after reset", int'(done), 0);

    // directed: plain timeout, answer, tie, wrong id on tie edge
    runSel(7, 2, 8'h41, 2, 1, 0, 0);
    runSel(5, 1, 8'h42, 2, 2, 1, 3);
    runSel(3, 6, 8'h41, 1, 3, 1, toLen(1, 3) + 1);
    runSel(0, 4, 8'h42, 2, 1, 2, toLen(2, 1) + 1);

    // R2: bus busy for a while before start of arbitration
    for (int r = 0; r < 4; r++) begin
      p = 2 + $urandom % 12;
      ownId = 3'd6; targetId = 3'd1; timeoutReg = 8'd1; clkFactor = 4'd1;
      busFree = 1'b0; arbWon = 1'b1;
      startCmd(8'h41);
      repeat (p - 1) @(negedge clk);
      busFree = 1'b1;
      waitEvt(0, at);
      chk("R2 busy poll interval", at, armEdge(firstPoll(p)));
      waitEvt(2, at);
    end

    // R5: lost arbitration, then retry and win
    ownId = 3'd2; targetId = 3'd5; busFree = 1'b1; arbWon = 1'b0;
    startCmd(8'h42);
    waitEvt(0, at); chk("R3 first arbitration", at, F + S + 2);
    waitEvt(3, at); chk("R5 lines dropped on loss", at, F + S + A + 3);
    chk("R5 data dropped on loss", int'(dataOut), 0);
    arbWon = 1'b1;
    waitEvt(0, at); chk("R5 retry arbitration", at, 2*F + 2*S + A + C + 5);
    waitEvt(1, at); chk("R6 selection after retry", at, 2*F + 3*S + 2*A + 2*C + 7);
    waitEvt(2, at);

    // R4: bus taken between poll and arbitration
    busFree = 1'b1;
    startCmd(8'h41);
    @(negedge clk); busFree = 1'b0;
    repeat (F + S + 1) @(negedge clk);
    chk("R4 no drive when bus busy", int'(bsyOut), 0);
    busFree = 1'b1;
    waitEvt(0, at); chk("R4 re-poll after clear delay", at, 2*F + 2*S + C + 4);
    waitEvt(2, at);

    // R12: start strobe during a running sequence is ignored
    ownId = 3'd1; targetId = 3'd3;
    startCmd(8'h41);
    waitEvt(0, at);
    @(negedge clk); startStb = 1'b1; cmdCode = 8'h42;
    @(negedge clk); startStb = 1'b0;
    waitEvt(1, at);
    chk("R12 selection timing unchanged", at, selEdge());
    chk("R12 atn unchanged", int'(atnOut), 0);
    waitEvt(2, at);

    // random mix
    for (int n = 0; n < 30; n++) begin
      int own, tgt, tr, cf, mode, k, pick;
      logic [7:0] cmd;
      own = $urandom % 8; tgt = (own + 1 + $urandom % 7) % 8;
      tr = 1 + $urandom % 6; cf = 1 + $urandom % 4;
      pick = $urandom % 3;
      cmd = (pick == 0) ? 8'h41 : (pick == 1) ? 8'h42 : 8'($urandom);
      mode = $urandom % 3;
      k = 1 + $urandom % (toLen(tr, cf) + 1);
      runSel(own, tgt, cmd, tr, cf, mode, k);
    end

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule